// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler with Postponement

This block keeps a four-bank DDR SDRAM refreshed on behalf of a memory controller. It counts clock cycles for the average refresh interval and adds one to a count of owed refreshes each time the interval expires. While refreshes are owed, it raises a request to the command arbiter. Once the arbiter grants the request and all banks are precharged, it issues one AUTO REFRESH. It then blocks every other command for the refresh cycle time. Owed refreshes may build up to a fixed cap. When the cap is reached the request turns urgent, and new row activates are withheld until a refresh has gone out.

The same handshake carries self-refresh. While the controller holds the self-refresh input high, the scheduler asks for the bus. It then issues the self-refresh entry command with CKE driven low, and clears the owed count because the device now refreshes itself. When the input drops, CKE returns high. Activates are then held off for one exit delay and reads for a second, longer one. All nanosecond timings are parameters and are converted to cycles by rounding up against the clock period.

Top module: `ddr_refresh_sched`

## Requirements
- R1: The owed count rises by one every REFI cycles, where REFI = ceil(T_REFI_NS*1000 / CLK_PERIOD_PS). The first increment lands on the REFI-th rising edge after reset is released.
- R2: The owed count never exceeds MAX_OWED. Interval expiries that arrive at the cap are dropped.
- R3: `ref_urgent` is high exactly when the owed count equals MAX_OWED, and `act_ok` is low while it is high.
- R4: On a rising edge where `ref_req`, `ref_gnt` and `banks_idle` are all high and `sr_enter` is low, `cmd_o` shows AUTO REFRESH (code 1) for the next cycle. For RFC = ceil(T_RFC_NS*1000 / CLK_PERIOD_PS) cycles starting with that one, `ref_req`, `act_ok` and `rd_ok` stay low. With the grant held high, consecutive refreshes are exactly RFC+1 cycles apart.
- R5: `cmd_o` is NOP (code 0) unless `banks_idle` and `ref_gnt` were both high at the previous rising edge.
- R6: On a granted edge with `sr_enter` high (with idle banks), `cmd_o` shows self-refresh entry (code 2) and `cke` goes low in the same cycle. The owed count becomes 0 and stays 0 while in self-refresh. The interval count restarts from zero once self-refresh ends.
- R7: `cke` returns high on the first rising edge at which `sr_enter` is seen low during self-refresh. `act_ok` rises exactly XSA = ceil(T_XSA_NS*1000 / CLK_PERIOD_PS) cycles later.
- R8: After self-refresh exit, `rd_ok` and `ref_req` stay low until exactly T_XSR_CYC cycles after `cke` rose.
- R9: `ref_done` pulses for one cycle together with each AUTO REFRESH, and the owed count drops by one on that edge.
- R10: During and right after reset: `cmd_o` is NOP, `cke` is high, the owed count is 0, `ref_req` is low, and `act_ok` and `rd_ok` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All four banks are precharged |
| ref_gnt | input | 1 | Arbiter grants the bus to the scheduler |
| sr_enter | input | 1 | Level: high to enter and stay in self-refresh, low to leave |
| ref_req | output | 1 | Request to the arbiter for a refresh or self-refresh entry slot |
| ref_urgent | output | 1 | Owed count is at its cap |
| cmd_o | output | 2 | Command: 0 NOP, 1 AUTO REFRESH, 2 self-refresh entry |
| cke | output | 1 | Clock enable to the memory |
| act_ok | output | 1 | A row activate may be issued this cycle |
| rd_ok | output | 1 | Reads and other commands may be issued this cycle |
| ref_done | output | 1 | One-cycle pulse per issued AUTO REFRESH |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of refreshes currently owed |

## Verification
The checker assumes that `sr_enter` changes only while the scheduler is running or in self-refresh. It also assumes the arbiter honours `act_ok` and `rd_ok` by itself, so the only command source it observes is `cmd_o`. The bench changes inputs only at falling edges. It holds `sr_enter` high from its request until the entry command appears, and drops it only after a stretch in self-refresh, so neither assumption is broken. Refresh timing is checked against windows counted from the command and CKE edges. The owed count is checked only for its cap, so postponement patterns produced by the grant and idle inputs are all legal stimulus.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_AREF = 2'd1,
      CMD_SREF = 2'd2
   } ref_cmd_e;

   typedef enum logic [1:0] {
      ST_RUN = 2'd0,
      ST_RFC = 2'd1,
      ST_SR  = 2'd2,
      ST_XS  = 2'd3
   } ref_state_e;

   // Round a picosecond duration up to whole clock cycles.
   function automatic int ps_to_cyc(input int dur_ps, input int period_ps);
      return (dur_ps + period_ps - 1) / period_ps;
   endfunction

endpackage

// File: rtl/ddr_ref_interval.sv
// Free-running interval timer: one tick per PERIOD enabled cycles.
module ddr_ref_interval #(
   parameter int PERIOD = 1040
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   logic [W-1:0] cnt;

   assign tick = run && (cnt == W'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= tick ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ddr_ref_owed.sv
// Saturating count of postponed refreshes.
module ddr_ref_owed #(
   parameter int MAX_OWED = 8,
   parameter int W        = $clog2(MAX_OWED + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         dec,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic         full
);
   generate
      if (MAX_OWED == 1) begin : g_flag
         logic owed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      owed_q <= 1'b0;
            else if (clr)    owed_q <= 1'b0;
            else if (tick)   owed_q <= 1'b1;
            else if (dec)    owed_q <= 1'b0;
         end
         assign cnt  = W'(owed_q);
         assign full = owed_q;
      end else begin : g_count
         logic [W-1:0] cnt_q;
         logic [W:0]   sum;
         always_comb begin
            sum = {1'b0, cnt_q} + (W+1)'(tick) - (W+1)'(dec);
            if (sum > (W+1)'(MAX_OWED)) sum = (W+1)'(MAX_OWED);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else          cnt_q <= sum[W-1:0];
         end
         assign cnt  = cnt_q;
         assign full = (cnt_q == W'(MAX_OWED));
      end
   endgenerate
endmodule

// File: rtl/ddr_ref_wait.sv
// Saturating up-counter timing refresh and exit windows.
module ddr_ref_wait #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (~&cnt)       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
   import ddr_ref_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 7500,
   parameter int T_REFI_NS     = 7800,
   parameter int T_RFC_NS      = 75,
   parameter int T_XSA_NS      = 75,
   parameter int T_XSR_CYC     = 200,
   parameter int MAX_OWED      = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          banks_idle,
   input  logic                          ref_gnt,
   input  logic                          sr_enter,
   output logic                          ref_req,
   output logic                          ref_urgent,
   output logic [1:0]                    cmd_o,
   output logic                          cke,
   output logic                          act_ok,
   output logic                          rd_ok,
   output logic                          ref_done,
   output logic [$clog2(MAX_OWED+1)-1:0] owed_cnt
);
   localparam int REFI_CYC = ps_to_cyc(T_REFI_NS * 1000, CLK_PERIOD_PS);
   localparam int RFC_CYC  = ps_to_cyc(T_RFC_NS * 1000, CLK_PERIOD_PS);
   localparam int XSA_CYC  = ps_to_cyc(T_XSA_NS * 1000, CLK_PERIOD_PS);
   localparam int XSR_CYC  = T_XSR_CYC;
   localparam int OWED_W   = $clog2(MAX_OWED + 1);
   localparam int WAIT_MAX = (RFC_CYC > XSR_CYC) ? RFC_CYC : XSR_CYC;
   localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

   generate
      if (CLK_PERIOD_PS < 1 || REFI_CYC < 2) begin : g_bad_refi
         $error("refresh interval must span at least two cycles");
      end
      if (RFC_CYC < 1 || XSA_CYC < 1) begin : g_bad_rfc
         $error("refresh and activate-exit windows must be at least one cycle");
      end
      if (XSR_CYC < XSA_CYC) begin : g_bad_xsr
         $error("read-exit window must not be shorter than activate-exit window");
      end
      if (MAX_OWED < 1) begin : g_bad_owed
         $error("owed cap must be at least one");
      end
   endgenerate

   ref_state_e          state_q;
   ref_cmd_e            cmd_q;
   logic                cke_q;
   logic                done_q;
   logic                tick;
   logic                owed_full;
   logic [OWED_W-1:0]   owed;
   logic [WAIT_W-1:0]   wcnt;
   logic                in_run, fire, go_sr, go_ar;
   logic                rfc_end, xs_end, sr_exit, wait_clr;

   always_comb begin
      in_run   = (state_q == ST_RUN);
      ref_req  = in_run && (sr_enter || (owed != '0));
      fire     = ref_req && ref_gnt && banks_idle;
      go_sr    = fire && sr_enter;
      go_ar    = fire && !sr_enter;
      rfc_end  = (state_q == ST_RFC) && (wcnt == WAIT_W'(RFC_CYC - 1));
      xs_end   = (state_q == ST_XS)  && (wcnt == WAIT_W'(XSR_CYC - 1));
      sr_exit  = (state_q == ST_SR)  && !sr_enter;
      wait_clr = go_ar || sr_exit;
   end

   ddr_ref_interval #(.PERIOD(REFI_CYC)) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != ST_SR),
      .clr   (go_sr),
      .tick  (tick)
   );

   ddr_ref_owed #(.MAX_OWED(MAX_OWED), .W(OWED_W)) u_owed (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .dec   (go_ar),
      .clr   (go_sr),
      .cnt   (owed),
      .full  (owed_full)
   );

   ddr_ref_wait #(.W(WAIT_W)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wait_clr),
      .cnt   (wcnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cmd_q   <= CMD_NOP;
         cke_q   <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         cmd_q  <= CMD_NOP;
         done_q <= 1'b0;
         unique case (state_q)
            ST_RUN: begin
               if (go_sr) begin
                  state_q <= ST_SR;
                  cmd_q   <= CMD_SREF;
                  cke_q   <= 1'b0;
               end else if (go_ar) begin
                  state_q <= ST_RFC;
                  cmd_q   <= CMD_AREF;
                  done_q  <= 1'b1;
               end
            end
            ST_RFC: if (rfc_end) state_q <= ST_RUN;
            ST_SR: begin
               if (sr_exit) begin
                  state_q <= ST_XS;
                  cke_q   <= 1'b1;
               end
            end
            ST_XS: if (xs_end) state_q <= ST_RUN;
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign cmd_o      = cmd_q;
   assign cke        = cke_q;
   assign ref_done   = done_q;
   assign owed_cnt   = owed;
   assign ref_urgent = owed_full;
   assign rd_ok      = in_run;
   assign act_ok     = !owed_full &&
                       (in_run || ((state_q == ST_XS) && (wcnt >= WAIT_W'(XSA_CYC))));
endmodule

// File: rtl/ddr_refresh_sched_chk.sv
module ddr_refresh_sched_chk #(
   parameter int RFC_CYC  = 10,
   parameter int XSA_CYC  = 10,
   parameter int XSR_CYC  = 200,
   parameter int MAX_OWED = 8,
   parameter int OWED_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              banks_idle,
   input logic              ref_gnt,
   input logic              ref_req,
   input logic              ref_urgent,
   input logic [1:0]        cmd_o,
   input logic              cke,
   input logic              act_ok,
   input logic              rd_ok,
   input logic              ref_done,
   input logic [OWED_W-1:0] owed_cnt
);
   localparam int GW = $clog2(RFC_CYC + 2);
   localparam int XW = $clog2(XSR_CYC + 2);

   logic [GW-1:0] gap;
   logic [XW-1:0] since_exit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap        <= GW'(RFC_CYC);
         since_exit <= XW'(XSR_CYC);
      end else begin
         if (cmd_o == 2'd1)             gap <= GW'(1);
         else if (gap < GW'(RFC_CYC))   gap <= gap + 1'b1;
         if ($rose(cke))                since_exit <= XW'(1);
         else if (since_exit < XW'(XSR_CYC)) since_exit <= since_exit + 1'b1;
      end
   end

   p_owed_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      owed_cnt <= OWED_W'(MAX_OWED));

   p_urgent_blocks_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> !act_ok);

   p_refresh_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd1) |-> (gap >= GW'(RFC_CYC)));

   p_cmd_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != 2'd0) |-> $past(banks_idle && ref_gnt && ref_req));

   p_cke_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> (cmd_o == 2'd2));

   p_sref_clears_owed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke) |-> (owed_cnt == '0));

   p_act_after_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      act_ok |-> (cke && !$rose(cke) && (since_exit >= XW'(XSA_CYC))));

   p_rd_after_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ok |-> (cke && !$rose(cke) && (since_exit >= XW'(XSR_CYC))));

   p_done_with_aref_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |-> (cmd_o == 2'd1));
endmodule

bind ddr_refresh_sched ddr_refresh_sched_chk #(
   .RFC_CYC  (RFC_CYC),
   .XSA_CYC  (XSA_CYC),
   .XSR_CYC  (XSR_CYC),
   .MAX_OWED (MAX_OWED),
   .OWED_W   (OWED_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .banks_idle (banks_idle),
   .ref_gnt    (ref_gnt),
   .ref_req    (ref_req),
   .ref_urgent (ref_urgent),
   .cmd_o      (cmd_o),
   .cke        (cke),
   .act_ok     (act_ok),
   .rd_ok      (rd_ok),
   .ref_done   (ref_done),
   .owed_cnt   (owed_cnt)
);

// File: tb/ddr_refresh_sched_tb.sv
`timescale 1ns/1ps
module ddr_refresh_sched_tb;
   // Small configuration: 8 ns clock, 160 ns interval -> 20 cycles,
   // 75 ns windows -> ceil(9.375) = 10 cycles, read exit 30 cycles.
   localparam int PER_PS = 8000;
   localparam int REFI   = (160 * 1000 + PER_PS - 1) / PER_PS;
   localparam int RFC    = (75 * 1000 + PER_PS - 1) / PER_PS;
   localparam int XSA    = (75 * 1000 + PER_PS - 1) / PER_PS;
   localparam int XSR    = 30;
   localparam int MAXO   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       banks_idle = 1'b0;
   logic       ref_gnt = 1'b0;
   logic       sr_enter = 1'b0;
   logic       ref_req, ref_urgent, cke, act_ok, rd_ok, ref_done;
   logic [1:0] cmd_o;
   logic [3:0] owed_cnt;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ddr_refresh_sched #(
      .CLK_PERIOD_PS (PER_PS),
      .T_REFI_NS     (160),
      .T_RFC_NS      (75),
      .T_XSA_NS      (75),
      .T_XSR_CYC     (XSR),
      .MAX_OWED      (MAXO)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .banks_idle (banks_idle),
      .ref_gnt    (ref_gnt),
      .sr_enter   (sr_enter),
      .ref_req    (ref_req),
      .ref_urgent (ref_urgent),
      .cmd_o      (cmd_o),
      .cke        (cke),
      .act_ok     (act_ok),
      .rd_ok      (rd_ok),
      .ref_done   (ref_done),
      .owed_cnt   (owed_cnt)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(8ns * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int last;
      int n_aref;
      int bad;
      int k;
      // R10 reset state
      step(2);
      check(cmd_o == 2'd0, "R10 cmd", cmd_o, 0);
      check(cke == 1'b1, "R10 cke", cke, 1);
      check(owed_cnt == 0, "R10 owed", owed_cnt, 0);
      check(!ref_req && act_ok && rd_ok, "R10 req/ok", {ref_req, act_ok, rd_ok}, 3);
      rst_n = 1'b1;

      // R1 first increment on edge REFI after release
      step(REFI - 1);
      check(owed_cnt == 0, "R1 before interval", owed_cnt, 0);
      step(1);
      check(owed_cnt == 1, "R1 after interval", owed_cnt, 1);
      check(ref_req == 1'b1, "R1 request raised", ref_req, 1);
      step(REFI);
      check(owed_cnt == 2, "R1 second interval", owed_cnt, 2);

      // R2/R3 postponement up to cap
      step(REFI * (MAXO - 2) - 1);
      check(owed_cnt == MAXO - 1, "R2 one below cap", owed_cnt, MAXO - 1);
      check(!ref_urgent && act_ok, "R3 not urgent", {ref_urgent, act_ok}, 1);
      step(1);
      check(owed_cnt == MAXO, "R2 at cap", owed_cnt, MAXO);
      check(ref_urgent && !act_ok, "R3 urgent blocks act", {ref_urgent, act_ok}, 2);
      step(REFI * 5);
      check(owed_cnt == MAXO, "R2 saturated", owed_cnt, MAXO);

      // R4/R9 drain with grant held
      banks_idle = 1'b1;
      ref_gnt    = 1'b1;
      last = -1;
      n_aref = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (cmd_o == 2'd1) begin
            if (n_aref == 0) begin
               check(i == 0, "R4 first refresh at grant", i, 0);
               check(owed_cnt == MAXO - 1, "R9 owed decremented", owed_cnt, MAXO - 1);
            end
            if (last >= 0) check(i - last == RFC + 1, "R4 spacing", i - last, RFC + 1);
            check(ref_done == 1'b1, "R9 done pulse", ref_done, 1);
            check(!ref_req && !rd_ok && !act_ok, "R4 hold-off",
                  {ref_req, rd_ok, act_ok}, 0);
            last = i;
            n_aref++;
         end else if (ref_done) begin
            check(1'b0, "R9 stray done", ref_done, 0);
         end
         if (owed_cnt == 0 && rd_ok) break;
      end
      check(n_aref >= MAXO, "R4 burst count", n_aref, MAXO);
      check(owed_cnt == 0 && !ref_req, "R4 drained", owed_cnt, 0);
      ref_gnt = 1'b0;

      // R5 grant without idle, idle without grant
      while (owed_cnt == 0) @(negedge clk);
      banks_idle = 1'b0;
      ref_gnt    = 1'b1;
      bad = 0;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (cmd_o != 2'd0 || owed_cnt == 0) bad++;
      end
      check(bad == 0, "R5 busy banks", bad, 0);
      banks_idle = 1'b1;
      ref_gnt    = 1'b0;
      bad = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (cmd_o != 2'd0) bad++;
      end
      check(bad == 0, "R5 no grant", bad, 0);

      // R6 self-refresh entry with refreshes owed
      check(owed_cnt != 0, "R6 owed before entry", owed_cnt, 1);
      sr_enter = 1'b1;
      ref_gnt  = 1'b1;
      step(1);
      check(cmd_o == 2'd2, "R6 entry command", cmd_o, 2);
      check(cke == 1'b0, "R6 cke low", cke, 0);
      check(owed_cnt == 0, "R6 owed cleared", owed_cnt, 0);
      ref_gnt = 1'b0;
      bad = 0;
      for (int i = 0; i < 3 * REFI; i++) begin
         @(negedge clk);
         if (cke || owed_cnt != 0 || ref_req || cmd_o != 2'd0 || rd_ok || act_ok) bad++;
      end
      check(bad == 0, "R6 held in self-refresh", bad, 0);

      // R7/R8 exit windows
      sr_enter = 1'b0;
      step(1);
      check(cke == 1'b1, "R7 cke high", cke, 1);
      for (k = 0; k <= XSR + 2; k++) begin
         if (k > 0) @(negedge clk);
         check(act_ok == (k >= XSA), "R7 act window", act_ok, (k >= XSA));
         check(rd_ok == (k >= XSR), "R8 read window", rd_ok, (k >= XSR));
         if (k < XSR) check(!ref_req, "R8 no request in exit", ref_req, 0);
         if (k == REFI - 1) check(owed_cnt == 0, "R6 interval restart early", owed_cnt, 0);
         if (k == REFI)     check(owed_cnt == 1, "R6 interval restart", owed_cnt, 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule